// File: doc/BRIEF.md
# SDRAM Row-Activation Timing Guard

This block sits beside the command pins of a four-bank double-data-rate SDRAM and checks every command against the row-activation timing rules. On each rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable levels into Activate, Precharge, Read, Write or no-operation, together with a 2-bit bank number. For each bank it keeps an open/idle state and two saturating cycle counters: cycles since the last Activate and cycles since the last Precharge. One shared counter keeps the cycles since the most recent Activate to any bank.

A command that arrives too early, or in a state where it is illegal, produces a one-cycle violation pulse and a 3-bit cause code. The bank state is still updated as though the command had been accepted, so the block mirrors what the memory will actually do. Per-bank ready vectors tell a command scheduler, one cycle ahead, which commands would be accepted if issued now. All five minimum intervals are elaboration-time parameters in whole clock cycles.

Top module: `sdram_act_guard`

## Requirements
- R1: After a synchronous active-high reset every bank is idle and every interval counter is saturated: `viol` is 0, `viol_code` is 0, `rdy_act` and `rdy_pre` are all ones and `rdy_rw` is all zeros.
- R2: Commands are decoded from (cs_n, ras_n, cas_n, we_n): 0,0,1,1 is Activate; 0,0,1,0 is Precharge; 0,1,0,1 is Read; 0,1,0,0 is Write; cs_n high or any other pattern is a no-operation that changes no state.
- R3: A Read or Write to an idle bank reports code 1 (no open row).
- R4: A Read or Write to an open bank fewer than T_RCD cycles after that bank's Activate reports code 2.
- R5: An Activate fewer than T_RRD cycles after an Activate to a different bank reports code 3.
- R6: A Precharge to an open bank fewer than T_RAS cycles after its Activate reports code 4.
- R7: An Activate fewer than T_RP cycles after a Precharge of the same bank reports code 5.
- R8: An Activate fewer than T_RC cycles after the previous Activate of the same bank reports code 6.
- R9: An Activate to a bank that already has an open row reports code 7.
- R10: `viol` is high, and `viol_code` holds the cause, for exactly the one cycle after the clock edge that sampled the offending command; otherwise `viol_code` is 0. When several Activate rules fail, the code is chosen in the order 7, then 6, then 5, then 3.
- R11: A violating command still updates state: a violating Activate opens the bank and restarts its counters, and a violating Read or Write leaves the bank untouched.
- R12: A Precharge to an idle bank is accepted without a violation and does not restart that bank's precharge counter.
- R13: `rdy_act[b]`, `rdy_rw[b]` and `rdy_pre[b]` are high exactly when an Activate, Read/Write or Precharge to bank b issued at the next edge would raise no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples the pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Target bank number |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Violation cause, 0 when none |
| rdy_act | output | 4 | Per-bank: Activate would be accepted |
| rdy_rw | output | 4 | Per-bank: Read or Write would be accepted |
| rdy_pre | output | 4 | Per-bank: Precharge would be accepted |

## Verification
The violation pulse and code are registered, so they appear just after the edge that sampled the command and clear one edge later; the ready vectors are derived from registered state and reflect all commands up to and including the last sampled edge. The bench drives pins on the falling edge, returns them to no-operation one nanosecond after the rising edge, and samples every output at that same point, so a command issued k edges after another sees an interval of exactly k cycles. Each interval rule is probed at one cycle short of its limit and again at the limit, with resets between scenarios so that earlier counters never leak in.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_PRE = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } cmd_e;

   typedef enum logic [2:0] {
      ERR_NONE   = 3'd0,
      ERR_NO_ROW = 3'd1,
      ERR_TRCD   = 3'd2,
      ERR_TRRD   = 3'd3,
      ERR_TRAS   = 3'd4,
      ERR_TRP    = 3'd5,
      ERR_TRC    = 3'd6,
      ERR_OPEN   = 3'd7
   } err_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ag_cmd_decode.sv
module ag_cmd_decode
   import act_guard_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = CMD_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ag_sat_counter.sv
module ag_sat_counter #(
   parameter int W    = 3,
   parameter int MAXV = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         restart,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] TOP = W'(MAXV);
   localparam logic [W-1:0] ONE = W'(1);

   initial begin
      if (MAXV >= (1 << W)) $error("ag_sat_counter: MAXV does not fit in W bits");
   end

   always_ff @(posedge clk) begin
      if (rst)               q <= TOP;
      else if (restart)      q <= ONE;
      else if (q != TOP)     q <= q + ONE;
   end

   AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst) q <= TOP && q != '0); // R1
endmodule

// File: rtl/ag_bank_timer.sv
module ag_bank_timer
   import act_guard_pkg::*;
#(
   parameter int CNT_W = 3,
   parameter int CMAX  = 7,
   parameter int T_RCD = 2,
   parameter int T_RAS = 5,
   parameter int T_RP  = 2,
   parameter int T_RC  = 7
) (
   input  logic clk,
   input  logic rst,
   input  logic act_i,
   input  logic pre_i,
   input  logic rw_i,
   output logic open_o,
   output err_e err_o,
   output logic ok_act_o,
   output logic ok_rw_o,
   output logic ok_pre_o
);
   localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
   localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);
   localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
   localparam logic [CNT_W-1:0] LIM_RC  = CNT_W'(T_RC);

   logic             open_q;
   logic [CNT_W-1:0] since_act;
   logic [CNT_W-1:0] since_pre;
   logic             pre_hit;

   assign pre_hit = pre_i && open_q;

   ag_sat_counter #(.W(CNT_W), .MAXV(CMAX)) i_act_cnt (
      .clk(clk), .rst(rst), .restart(act_i), .q(since_act)
   );

   ag_sat_counter #(.W(CNT_W), .MAXV(CMAX)) i_pre_cnt (
      .clk(clk), .rst(rst), .restart(pre_hit), .q(since_pre)
   );

   always_ff @(posedge clk) begin
      if (rst)          open_q <= 1'b0;
      else if (act_i)   open_q <= 1'b1;
      else if (pre_hit) open_q <= 1'b0;
   end

   // Bank-local rule checks; the cross-bank spacing rule is added at the top.
   always_comb begin
      ok_act_o = !open_q && (since_act >= LIM_RC) && (since_pre >= LIM_RP);
      ok_rw_o  = open_q && (since_act >= LIM_RCD);
      ok_pre_o = !open_q || (since_act >= LIM_RAS);
   end

   always_comb begin
      err_o = ERR_NONE;
      if (act_i) begin
         if (open_q)                   err_o = ERR_OPEN;
         else if (since_act < LIM_RC)  err_o = ERR_TRC;
         else if (since_pre < LIM_RP)  err_o = ERR_TRP;
      end else if (rw_i) begin
         if (!open_q)                  err_o = ERR_NO_ROW;
         else if (since_act < LIM_RCD) err_o = ERR_TRCD;
      end else if (pre_hit) begin
         if (since_act < LIM_RAS)      err_o = ERR_TRAS;
      end
   end

   assign open_o = open_q;

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst) act_i |=> open_q && since_act == CNT_W'(1)); // R11
   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst) (pre_i && open_q && !act_i) |=> !open_q); // R6
   AST_IDLE_PRE_KEEPS: assert property (@(posedge clk) disable iff (rst) (pre_i && !open_q && !act_i) |=> !open_q && since_pre != CNT_W'(1)); // R12
   AST_RW_NO_CHANGE: assert property (@(posedge clk) disable iff (rst) (rw_i && !act_i && !pre_i) |=> $stable(open_q)); // R11
endmodule

// File: rtl/ag_rrd_timer.sv
module ag_rrd_timer #(
   parameter int NB    = 4,
   parameter int BA_W  = 2,
   parameter int CNT_W = 3,
   parameter int CMAX  = 7,
   parameter int T_RRD = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            act_i,
   input  logic [BA_W-1:0] act_bank_i,
   output logic [NB-1:0]   ok_o
);
   generate
      if (T_RRD <= 1) begin : g_no_rrd
         // Back-to-back Activates are always legal across banks.
         assign ok_o = '1;
      end else begin : g_rrd
         localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);
         logic [CNT_W-1:0] since_any;
         logic [BA_W-1:0]  last_bank;

         ag_sat_counter #(.W(CNT_W), .MAXV(CMAX)) i_any_cnt (
            .clk(clk), .rst(rst), .restart(act_i), .q(since_any)
         );

         always_ff @(posedge clk) begin
            if (rst)        last_bank <= '0;
            else if (act_i) last_bank <= act_bank_i;
         end

         for (genvar b = 0; b < NB; b++) begin : g_ok
            assign ok_o[b] = (last_bank == BA_W'(b)) || (since_any >= LIM_RRD);
         end

         AST_RRD_LAST: assert property (@(posedge clk) disable iff (rst) act_i |=> last_bank == $past(act_bank_i)); // R5
      end
   endgenerate
endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
   import act_guard_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RCD     = 2,
   parameter int T_RRD     = 2,
   parameter int T_RAS     = 5,
   parameter int T_RP      = 2,
   parameter int T_RC      = 7
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cs_n,
   input  logic                         ras_n,
   input  logic                         cas_n,
   input  logic                         we_n,
   input  logic [$clog2(NUM_BANKS)-1:0] bank,
   output logic                         viol,
   output logic [2:0]                   viol_code,
   output logic [NUM_BANKS-1:0]         rdy_act,
   output logic [NUM_BANKS-1:0]         rdy_rw,
   output logic [NUM_BANKS-1:0]         rdy_pre
);
   localparam int BA_W  = $clog2(NUM_BANKS);
   localparam int CMAX  = max_of(max_of(max_of(T_RCD, T_RRD), max_of(T_RAS, T_RP)), max_of(T_RC, 1));
   localparam int CNT_W = $clog2(CMAX + 1);

   generate
      if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
         $error("sdram_act_guard: NUM_BANKS must be a power of two of at least 2");
      end
      if (T_RCD < 1 || T_RRD < 1 || T_RAS < 1 || T_RP < 1 || T_RC < 1) begin : g_bad_time
         $error("sdram_act_guard: every interval must be at least one cycle");
      end
   endgenerate

   cmd_e                 cmd;
   logic [NUM_BANKS-1:0] sel;
   logic [NUM_BANKS-1:0] bank_open;
   logic [NUM_BANKS-1:0] ok_act_local;
   logic [NUM_BANKS-1:0] ok_rrd;
   err_e                 bank_err [NUM_BANKS];
   err_e                 err_now;
   logic                 is_act;
   logic                 viol_q;
   err_e                 code_q;

   ag_cmd_decode i_decode (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   assign is_act = (cmd == CMD_ACT);

   always_comb begin
      sel       = '0;
      sel[bank] = 1'b1;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ag_bank_timer #(
         .CNT_W(CNT_W), .CMAX(CMAX),
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
      ) i_timer (
         .clk      (clk),
         .rst      (rst),
         .act_i    (sel[b] && is_act),
         .pre_i    (sel[b] && cmd == CMD_PRE),
         .rw_i     (sel[b] && (cmd == CMD_RD || cmd == CMD_WR)),
         .open_o   (bank_open[b]),
         .err_o    (bank_err[b]),
         .ok_act_o (ok_act_local[b]),
         .ok_rw_o  (rdy_rw[b]),
         .ok_pre_o (rdy_pre[b])
      );
   end

   ag_rrd_timer #(
      .NB(NUM_BANKS), .BA_W(BA_W), .CNT_W(CNT_W), .CMAX(CMAX), .T_RRD(T_RRD)
   ) i_rrd (
      .clk(clk), .rst(rst), .act_i(is_act), .act_bank_i(bank), .ok_o(ok_rrd)
   );

   assign rdy_act = ok_act_local & ok_rrd;

   // Cross-bank spacing is lowest priority among Activate causes.
   always_comb begin
      err_now = bank_err[bank];
      if (is_act && err_now == ERR_NONE && !ok_rrd[bank]) err_now = ERR_TRRD;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         viol_q <= 1'b0;
         code_q <= ERR_NONE;
      end else begin
         viol_q <= (err_now != ERR_NONE);
         code_q <= err_now;
      end
   end

   assign viol      = viol_q;
   assign viol_code = code_q;

   AST_RW_IDLE: assert property (@(posedge clk) disable iff (rst) ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[bank]) |=> viol && viol_code == 3'd1); // R3
   AST_ACT_OPEN: assert property (@(posedge clk) disable iff (rst) (is_act && bank_open[bank]) |=> viol && viol_code == 3'd7); // R9
   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst) (cmd == CMD_NOP) |=> !viol && viol_code == 3'd0); // R10
   AST_RDY_EXCL: assert property (@(posedge clk) disable iff (rst) (rdy_act & rdy_rw) == '0); // R13
   AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (rst) (cmd == CMD_NOP) |=> $stable(bank_open)); // R2
endmodule

// File: tb/test_sdram_act_guard.sv
module test_sdram_act_guard;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] bank = 2'd0;
   logic       viol;
   logic [2:0] viol_code;
   logic [3:0] rdy_act, rdy_rw, rdy_pre;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   localparam int ACT = 1, PRE = 2, RD = 3, WR = 4;

   always #2 clk = ~clk;

   sdram_act_guard i_sdram_act_guard (
      .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .bank(bank), .viol(viol), .viol_code(viol_code),
      .rdy_act(rdy_act), .rdy_rw(rdy_rw), .rdy_pre(rdy_pre)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic pins_nop();
      cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
   endtask

   // Drive on the falling edge, sample 1 ns after the rising edge, then idle.
   task automatic issue(input int c, input int b, input string req, input int exp_code);
      @(negedge clk);
      bank = 2'(b);
      cs_n = 1'b0;
      case (c)
         ACT: {ras_n, cas_n, we_n} = 3'b011;
         PRE: {ras_n, cas_n, we_n} = 3'b010;
         RD:  {ras_n, cas_n, we_n} = 3'b101;
         default: {ras_n, cas_n, we_n} = 3'b100;
      endcase
      @(posedge clk); #1;
      pins_nop();
      chk({req, " code"}, int'(viol_code), exp_code);
      chk({req, " pulse"}, int'(viol), (exp_code != 0) ? 1 : 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; pins_nop();
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      idle(1);
      chk("R1 viol", int'(viol), 0);
      chk("R1 code", int'(viol_code), 0);
      chk("R1 rdy_act", int'(rdy_act), 15);
      chk("R1 rdy_rw", int'(rdy_rw), 0);
      chk("R1 rdy_pre", int'(rdy_pre), 15);
   endtask

   task automatic t_decode();
      do_reset();
      // Activate pattern with chip select high is a no-operation
      @(negedge clk); bank = 2'd0; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011;
      @(posedge clk); #1; pins_nop();
      chk("R2 cs_n high no viol", int'(viol), 0);
      chk("R2 cs_n high no open", int'(rdy_rw), 0);
      // Unused pattern (all strobes low) is a no-operation
      @(negedge clk); cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b000;
      @(posedge clk); #1; pins_nop();
      chk("R2 other pattern", int'(viol), 0);
      issue(RD, 0, "R2 R3 read idle", 1);
      issue(WR, 2, "R2 R3 write idle", 1);
      idle(1);
      chk("R10 pulse clears", int'(viol), 0);
      chk("R10 code clears", int'(viol_code), 0);
   endtask

   task automatic t_rcd();
      do_reset();
      issue(ACT, 0, "R4 act", 0);
      issue(RD, 0, "R4 read early", 2);
      issue(WR, 0, "R4 R11 write at limit", 0);
   endtask

   task automatic t_rrd();
      do_reset();
      issue(ACT, 0, "R5 act b0", 0);
      issue(ACT, 1, "R5 act b1 early", 3);
      idle(1);
      issue(ACT, 2, "R5 act b2 at limit", 0);
      issue(RD, 1, "R11 b1 opened by violating act", 0);
   endtask

   task automatic t_ras();
      do_reset();
      issue(ACT, 0, "R6 act", 0);
      idle(3);
      issue(PRE, 0, "R6 pre early", 4);
      do_reset();
      issue(ACT, 0, "R6 act", 0);
      idle(4);
      issue(PRE, 0, "R6 pre at limit", 0);
   endtask

   task automatic t_rp();
      do_reset();
      issue(ACT, 3, "R7 act", 0);
      idle(7);
      issue(PRE, 3, "R7 pre", 0);
      issue(ACT, 3, "R7 act early", 5);
      do_reset();
      issue(ACT, 3, "R7 act", 0);
      idle(7);
      issue(PRE, 3, "R7 pre", 0);
      idle(1);
      issue(ACT, 3, "R7 act at limit", 0);
   endtask

   task automatic t_rc();
      do_reset();
      issue(ACT, 1, "R8 act", 0);
      idle(3);
      issue(PRE, 1, "R8 pre", 4);
      idle(1);
      issue(ACT, 1, "R8 act early", 6);
      do_reset();
      issue(ACT, 1, "R10 act", 0);
      idle(4);
      issue(PRE, 1, "R10 pre", 0);
      issue(ACT, 1, "R10 tRC over tRP", 6);
      do_reset();
      issue(ACT, 1, "R8 act", 0);
      idle(4);
      issue(PRE, 1, "R8 pre", 0);
      idle(1);
      issue(ACT, 1, "R8 act at limit", 0);
   endtask

   task automatic t_open();
      do_reset();
      issue(ACT, 2, "R9 act", 0);
      idle(9);
      issue(ACT, 2, "R9 act on open", 7);
      issue(ACT, 0, "R10 open over tRRD", 3);
   endtask

   task automatic t_idle_pre();
      do_reset();
      issue(PRE, 1, "R12 pre idle", 0);
      chk("R12 still ready", int'(rdy_act[1]), 1);
      issue(ACT, 1, "R12 act after idle pre", 0);
   endtask

   task automatic t_ready();
      do_reset();
      issue(ACT, 0, "R13 act", 0);
      chk("R13 rdy_act t1", int'(rdy_act), 0);
      chk("R13 rdy_rw t1", int'(rdy_rw), 0);
      chk("R13 rdy_pre t1", int'(rdy_pre), 14);
      idle(1);
      chk("R13 rdy_act t2", int'(rdy_act), 14);
      chk("R13 rdy_rw t2", int'(rdy_rw), 1);
      chk("R13 rdy_pre t2", int'(rdy_pre), 14);
      idle(3);
      chk("R13 rdy_pre t5", int'(rdy_pre), 15);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_decode();
      t_rcd();
      t_rrd();
      t_ras();
      t_rp();
      t_rc();
      t_open();
      t_idle_pre();
      t_ready();
      finish_run();
   end

   initial begin
      #400000;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule